// File: doc/BRIEF.md
# Pipelined Array Multiplier with Truncated Product

This block multiplies an operand X by an operand Y. It uses a linear array of add rows, one row for each bit of Y. Row `i` adds X shifted left by `i` into a running sum when bit `i` of Y is set. In signed mode the row for the top bit of Y subtracts instead of adding, and X is sign-extended inside each row.

The full product is `XW+YW` bits wide. The output bus is `PW` bits wide and may be narrower. When it is, the output keeps the most significant product bits and simply discards the low bits, with no rounding.

Three parameters are fixed at build time: the signedness, the widths, and a register spacing `SPACING`.
- `SPACING = 0` gives a purely combinational array.
- `SPACING = N` places a register rank after every Nth row and always after the last row.
- The latency in clock cycles is `(YW-1)/SPACING + 1`, using integer division.

A clock enable freezes every rank. A synchronous active-high reset clears every rank.

Top module: `arr_mult_top`

## Requirements
- R1: In unsigned mode (`SIGNED=0`) with `PW = XW+YW`, `p_out` equals `x_in * y_in`, with both operands treated as unsigned.
- R2: In signed mode (`SIGNED=1`), both operands are read as two's complement, and `p_out` carries bits `[XW+YW-1 : XW+YW-PW]` of the two's-complement product.
- R3: An array row whose Y bit is 0 passes the running sum through unchanged. A row whose Y bit is 1 adds X shifted left by the row index.
- R4: In signed mode, the row driven by the most significant Y bit subtracts the shifted, sign-extended X from the running sum.
- R5: With `SPACING > 0`, a result appears on `p_out` exactly `(YW-1)/SPACING + 1` enabled clock edges after its operands are applied. With `SPACING = 0`, `p_out` follows the operands with no clock.
- R6: While `ce` is 0, every register rank holds its value, and `p_out` does not change whatever the operands do. When `ce` returns to 1, the frozen data continues down the pipeline.
- R7: One clock edge with `rst` high drives `p_out` to zero and clears all pipeline state.
- R8: A narrow output drops the low product bits by truncation. For example, signed `-1 * 1` gives all ones, and `1 * 15` gives zero when 4 low bits are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all register ranks |
| x_in | input | XW | Multiplicand |
| y_in | input | YW | Multiplier; one array row per bit |
| p_out | output | PW | Upper PW bits of the product |

## Verification
The hardest situation to reach from the ports is a pipeline frozen mid-flight with `ce` low while the operands keep changing. The bench fills the ranks with one operand pair, drops `ce`, and applies a different pair for several cycles. It then checks that the output never moves, and that the held pair, not the new one, emerges after enable returns. Sign and truncation corners come from table vectors at the operand extremes, including most-negative times most-negative and products smaller than the dropped bits. A second instance, combinational and unsigned, covers the other parameter variants.

// File: rtl/arr_mult_pkg.sv
package arr_mult_pkg;

  // Number of register ranks for a given row count and spacing.
  function automatic int rank_count(input int rows, input int spacing);
    if (spacing <= 0) return 0;
    return ((rows - 1) / spacing) + 1;
  endfunction

  // True when a register rank follows row idx.
  function automatic bit row_is_registered(input int idx, input int rows,
                                           input int spacing);
    if (spacing <= 0) return 1'b0;
    return (((idx + 1) % spacing) == 0) || (idx == rows - 1);
  endfunction

endpackage

// File: rtl/arr_mult_row.sv
module arr_mult_row #(
  parameter int XW     = 8,
  parameter int PRODW  = 14,
  parameter int IDX    = 0,
  parameter bit SIGNED = 1'b1,
  parameter bit LAST   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRODW-1:0] acc_in,
  input  logic [XW-1:0]    x_in,
  input  logic             y_bit,
  output logic [PRODW-1:0] acc_out
);
  localparam int EXTW = PRODW - XW;
  localparam bit SUBTRACT = SIGNED && LAST;

  logic [PRODW-1:0] x_ext;
  logic [PRODW-1:0] addend;

  always_comb begin
    if (SIGNED) x_ext = {{EXTW{x_in[XW-1]}}, x_in};
    else        x_ext = {{EXTW{1'b0}}, x_in};
    addend = y_bit ? (x_ext << IDX) : '0;
    if (SUBTRACT) acc_out = acc_in - addend;
    else          acc_out = acc_in + addend;
  end

  // R3: a cleared Y bit leaves the running sum untouched
  assert_row_pass_R3: assert property (@(posedge clk) disable iff (rst)
    !y_bit |-> (acc_out == acc_in));

  // R4: the sign row moves the sum down by the shifted operand
  generate
    if (SUBTRACT) begin : g_sign_chk
      assert_sign_row_R4: assert property (@(posedge clk) disable iff (rst)
        y_bit |-> ((acc_out + (x_ext << IDX)) == acc_in));
    end
  endgenerate

endmodule

// File: rtl/arr_mult_rank.sv
module arr_mult_rank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end

  // R6: a disabled rank keeps its contents
  assert_rank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

endmodule

// File: rtl/arr_mult_trunc.sv
module arr_mult_trunc #(
  parameter int PRODW = 14,
  parameter int PW    = 10
) (
  input  logic [PRODW-1:0] full,
  output logic [PW-1:0]    upper
);
  localparam int DROP = PRODW - PW;

  initial begin
    if (PW > PRODW || PW < 1)
      $error("arr_mult_trunc: output width %0d out of range", PW);
  end

  // R8: keep only the top PW bits, no rounding
  assign upper = full[PRODW-1:DROP];

endmodule

// File: rtl/arr_mult_top.sv
module arr_mult_top
  import arr_mult_pkg::*;
#(
  parameter int XW      = 8,
  parameter int YW      = 6,
  parameter int PW      = 10,
  parameter bit SIGNED  = 1'b1,
  parameter int SPACING = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  output logic [PW-1:0] p_out
);
  localparam int PRODW  = XW + YW;
  localparam int BUNDLE = PRODW + XW + YW;
  localparam int RANKS  = rank_count(YW, SPACING);

  logic [PRODW-1:0] acc_s [YW+1];
  logic [XW-1:0]    x_s   [YW+1];
  logic [YW-1:0]    y_s   [YW+1];
  logic [PRODW-1:0] acc_c [YW];

  assign acc_s[0] = '0;
  assign x_s[0]   = x_in;
  assign y_s[0]   = y_in;

  generate
    for (genvar g = 0; g < YW; g++) begin : g_row
      arr_mult_row #(
        .XW(XW), .PRODW(PRODW), .IDX(g),
        .SIGNED(SIGNED), .LAST(g == YW - 1)
      ) u_row (
        .clk    (clk),
        .rst    (rst),
        .acc_in (acc_s[g]),
        .x_in   (x_s[g]),
        .y_bit  (y_s[g][g]),
        .acc_out(acc_c[g])
      );

      if (row_is_registered(g, YW, SPACING)) begin : g_reg
        logic [BUNDLE-1:0] q_w;
        arr_mult_rank #(.W(BUNDLE)) u_rank (
          .clk(clk),
          .rst(rst),
          .ce (ce),
          .d  ({acc_c[g], x_s[g], y_s[g]}),
          .q  (q_w)
        );
        assign acc_s[g+1] = q_w[BUNDLE-1 -: PRODW];
        assign x_s[g+1]   = q_w[YW +: XW];
        assign y_s[g+1]   = q_w[YW-1:0];
      end else begin : g_wire
        assign acc_s[g+1] = acc_c[g];
        assign x_s[g+1]   = x_s[g];
        assign y_s[g+1]   = y_s[g];
      end
    end
  endgenerate

  arr_mult_trunc #(.PRODW(PRODW), .PW(PW)) u_trunc (
    .full (acc_s[YW]),
    .upper(p_out)
  );

  // Checks on the output port
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R7: after a reset edge the product reads zero
    if (RANKS > 0 && rst_q)
      assert_reset_zero_R7: assert (p_out == '0);
  end

  generate
    if (RANKS > 0) begin : g_out_chk
      // R6: output frozen while the enable is low
      assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(p_out));
    end
  endgenerate

endmodule

// File: tb/tb_arr_mult_top.sv
module tb_arr_mult_top;
  localparam int XW = 8;
  localparam int YW = 6;
  localparam int PW = 10;
  localparam int SP = 2;
  localparam int LAT = ((YW - 1) / SP) + 1;   // 3
  localparam int FW = XW + YW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b1;
  logic [XW-1:0] x = '0;
  logic [YW-1:0] y = '0;
  logic [PW-1:0] p_s;
  logic [FW-1:0] p_u;

  always #10 clk = ~clk;  // 50 MHz

  arr_mult_top #(.XW(XW), .YW(YW), .PW(PW), .SIGNED(1'b1), .SPACING(SP)) dut (
    .clk(clk), .rst(rst), .ce(ce), .x_in(x), .y_in(y), .p_out(p_s));

  arr_mult_top #(.XW(XW), .YW(YW), .PW(FW), .SIGNED(1'b0), .SPACING(0)) dut_u (
    .clk(clk), .rst(rst), .ce(ce), .x_in(x), .y_in(y), .p_out(p_u));

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam int NV = 14;
  localparam logic [NV-1:0][XW+YW-1:0] VEC = '{
    {8'h00, 6'h00}, {8'h01, 6'h01}, {8'hFF, 6'h01}, {8'h01, 6'h0F},
    {8'h80, 6'h20}, {8'h7F, 6'h1F}, {8'h80, 6'h1F}, {8'h7F, 6'h20},
    {8'hFF, 6'h3F}, {8'h55, 6'h2A}, {8'h3C, 6'h11}, {8'hC3, 6'h0B},
    {8'h12, 6'h34}, {8'hA7, 6'h3E}
  };

  function automatic logic [PW-1:0] exp_s(input logic [XW-1:0] a,
                                          input logic [YW-1:0] b);
    logic signed [FW-1:0] ea, eb, f;
    ea = FW'($signed(a));
    eb = FW'($signed(b));
    f  = ea * eb;
    return f[FW-1 -: PW];
  endfunction

  function automatic logic [FW-1:0] exp_u(input logic [XW-1:0] a,
                                          input logic [YW-1:0] b);
    return FW'(a) * FW'(b);
  endfunction

  task automatic chk(input string req, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [PW-1:0] held;
    repeat (2) step();
    rst = 1'b0;
    // R7: reset state
    chk("R7 reset state", FW'(p_s), '0);

    // Streamed table: check vector j-LAT, then drive vector j
    for (int j = 0; j < NV + LAT; j++) begin
      if (j >= LAT)
        chk("R2/R5/R8 signed pipelined", FW'(p_s),
            FW'(exp_s(VEC[NV-1-(j-LAT)][FW-1 -: XW], VEC[NV-1-(j-LAT)][YW-1:0])));
      if (j < NV) begin
        x = VEC[NV-1-j][FW-1 -: XW];
        y = VEC[NV-1-j][YW-1:0];
        #1;
        // R1/R3/R5: combinational unsigned instance follows at once
        chk("R1/R3/R5 unsigned comb", p_u, exp_u(x, y));
      end
      step();
    end

    // R8: truncation corners, directly
    x = 8'hFF; y = 6'h01; repeat (LAT) step();
    chk("R8 -1*1 floors to all ones", FW'(p_s), FW'(10'h3FF));
    x = 8'h01; y = 6'h0F; repeat (LAT) step();
    chk("R8 1*15 drops to zero", FW'(p_s), '0);
    // R4: most negative squared
    x = 8'h80; y = 6'h20; repeat (LAT) step();
    chk("R4 sign row -128*-32", FW'(p_s), FW'(exp_s(8'h80, 6'h20)));

    // R6: freeze mid-flight
    x = 8'h33; y = 6'h05; repeat (LAT) step();
    held = p_s;
    chk("R5 before freeze", FW'(held), FW'(exp_s(8'h33, 6'h05)));
    x = 8'h9A; y = 6'h1B; step();        // new pair enters first rank
    ce = 1'b0;
    for (int k = 0; k < 5; k++) begin
      x = 8'(k * 37 + 5); y = 6'(k * 11 + 3);
      step();
      chk("R6 output frozen", FW'(p_s), FW'(held));
    end
    x = 8'h00; y = 6'h00;
    ce = 1'b1;
    repeat (LAT - 1) step();
    chk("R6 held pair emerges", FW'(p_s), FW'(exp_s(8'h9A, 6'h1B)));

    // R7: reset in mid-stream
    x = 8'h7F; y = 6'h1F; step();
    rst = 1'b1; step();
    chk("R7 reset clears output", FW'(p_s), '0);
    rst = 1'b0;
    repeat (LAT) step();
    chk("R5 after reset", FW'(p_s), FW'(exp_s(8'h7F, 6'h1F)));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule